// File: doc/BRIEF.md
# Sequence-Unlocked Drive Timing Register Bank

This block decodes a small I/O window of eight byte or word offsets. It sits in front of an ordinary task-file port. In normal operation every access passes through to that port unchanged. A second bank of configuration registers sits behind the same offsets. That bank holds drive timing, a control byte, a clock-speed probe and a shared address-setup value, and it can only be reached after a short unlock handshake made of ordinary port accesses.

The handshake is two back-to-back word reads of offset 1 followed by a byte write of 0x03 to offset 2. After that the block is in configuration mode, and accesses land in the hidden bank instead of the port. A byte write of 0x83 to offset 2 closes the bank again.

Software first writes a device number to the miscellaneous register. It then writes that device's read-cycle and write-cycle timing bytes, and after that the address-setup value, which both devices share. A final commit byte in the control register makes the programmed values replace the strap defaults on the timing outputs. Each timing byte packs a data-active count in its upper nibble and a recovery count in its lower nibble; the block stores and presents the byte whole.

Top module: `cfg_trapdoor`

## Requirements
- R1: While reset (rstN low, synchronous) is held, the bank closes, the control byte clears to 0 so overrideOn is 0, and the stored timing bytes load the strap default for the current clkFast: 0x6B when clkFast=0, 0x58 when clkFast=1. The stored address setup loads 0x30 when clkFast=0 and 0x20 when clkFast=1.
- R2: While the bank is closed, every access is forwarded: tfStb equals ioStb, and ioRdata equals tfRdata.
- R3: Two consecutive word reads (ioWide=1, ioWr=0) at offset 1, then a byte write (ioWide=0) with data[7:0]=0x03 at offset 2, open the bank from the next access on.
- R4: Any access that breaks the R3 order clears the arming. Examples are a byte read at offset 1, or a write at offset 2 of a value other than 0x03 after the two reads. The bank then stays closed until two fresh word reads are seen. A third word read at offset 1 keeps the arming.
- R5: While the bank is open, tfStb stays 0 for every access.
- R6: While the bank is open, a byte write of 0x83 at offset 2 closes it from the next access on. Any other value written at offset 2 is ignored.
- R7: In the open bank, a write at offset 0 sets the read-cycle timing byte, and a write at offset 1 sets the write-cycle timing byte, of the currently selected device. Reads at those offsets return the selected device's stored byte on ioRdata[7:0], with upper bits 0.
- R8: A write at offset 6 with a value below 2 selects that device (0 or 1) for R7. A value of 2 or more becomes the shared address setup. A read at offset 6 returns the stored address setup.
- R9: A write at offset 3 stores the control byte, and a read at offset 3 returns it. overrideOn is 1 exactly while the stored control byte is 0x85.
- R10: With overrideOn=0, rdTiming and wrTiming (device d in bits [8d+7:8d]) and addrSetup show the strap defaults of R1 for the live clkFast. With overrideOn=1 they show the stored bytes.
- R11: In the open bank, a read at offset 5 returns clkFast in bit 0 only after the last write to offset 5 was 0xFF. Otherwise it returns 0.
- R12: Writes made while the bank is closed change no configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| clkFast | input | 1 | Bus-clock speed strap, 1 = fast |
| ioStb | input | 1 | One-cycle access strobe |
| ioWr | input | 1 | 1 = write, 0 = read |
| ioWide | input | 1 | 1 = word access, 0 = byte access |
| ioAddr | input | 3 | Offset from the command base |
| ioWdata | input | 16 | Write data |
| ioRdata | output | 16 | Read data, valid combinationally during a read strobe |
| tfStb | output | 1 | Forwarded strobe to the task-file port |
| tfWr | output | 1 | Forwarded write flag |
| tfWide | output | 1 | Forwarded width flag |
| tfAddr | output | 3 | Forwarded offset |
| tfWdata | output | 16 | Forwarded write data |
| tfRdata | input | 16 | Read data from the task-file port |
| rdTiming | output | 16 | Effective read-cycle timing, one byte per device |
| wrTiming | output | 16 | Effective write-cycle timing, one byte per device |
| addrSetup | output | 8 | Effective shared address-setup byte |
| overrideOn | output | 1 | Programmed timings replace strap defaults |

## Verification
The properties assume that each access is a single-cycle ioStb pulse whose width, offset and data are stable in that cycle. They also assume the key values at offset 2 are judged on ioWdata[7:0] alone. The stimulus drives one access per pulse at the falling edge and drops ioStb after the next rising edge. Directed cases cover broken and repeated handshakes. The random traffic draws offsets 1 and 2 and the key bytes 0x03 and 0x83 often enough that the bank is opened and closed many times. A bench model of the handshake predicts, for every access, whether it should be forwarded.

// File: rtl/trapdoor_pkg.sv
package trapdoor_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_RDTIM = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_WRTIM = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_ARM   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_KEY   = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_PROBE = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_MISC  = 3'd6;

  localparam logic [REG_W-1:0] KEY_OPEN    = 8'h03;
  localparam logic [REG_W-1:0] KEY_CLOSE   = 8'h83;
  localparam logic [REG_W-1:0] CTRL_COMMIT = 8'h85;
  localparam logic [REG_W-1:0] PROBE_CODE  = 8'hFF;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARM1   = 2'd1,
    ST_ARM2   = 2'd2,
    ST_OPEN   = 2'd3
  } trapState_t;

  typedef struct packed {
    logic cfgMode;
    logic wrRdTim;
    logic wrWrTim;
    logic wrCtrl;
    logic wrProbe;
    logic wrMisc;
  } cfgStrobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trapdoor_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStb,
  input  logic              ioWr,
  input  logic              ioWide,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [REG_W-1:0]  wrByte,
  output cfgStrobe_t        strb,
  output logic              fwdStb
);
  trapState_t state, stateNxt;
  logic armRead, openKey, closeKey, cfgOn, cfgWr;

  assign armRead  = ioStb && !ioWr && ioWide && (ioAddr == OFF_ARM);
  assign openKey  = ioStb && ioWr && !ioWide && (ioAddr == OFF_KEY) && (wrByte == KEY_OPEN);
  assign closeKey = ioStb && ioWr && !ioWide && (ioAddr == OFF_KEY) && (wrByte == KEY_CLOSE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_LOCKED: if (armRead) stateNxt = ST_ARM1;
      ST_ARM1: begin
        if (armRead)    stateNxt = ST_ARM2;
        else if (ioStb) stateNxt = ST_LOCKED;
      end
      ST_ARM2: begin
        if (armRead)      stateNxt = ST_ARM2;
        else if (openKey) stateNxt = ST_OPEN;
        else if (ioStb)   stateNxt = ST_LOCKED;
      end
      ST_OPEN: if (closeKey) stateNxt = ST_LOCKED;
      default: stateNxt = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNxt;
  end

  assign cfgOn = (state == ST_OPEN);
  assign cfgWr = cfgOn && ioStb && ioWr;

  always_comb begin
    strb         = '0;
    strb.cfgMode = cfgOn;
    strb.wrRdTim = cfgWr && (ioAddr == OFF_RDTIM);
    strb.wrWrTim = cfgWr && (ioAddr == OFF_WRTIM);
    strb.wrCtrl  = cfgWr && (ioAddr == OFF_CTRL);
    strb.wrProbe = cfgWr && (ioAddr == OFF_PROBE);
    strb.wrMisc  = cfgWr && (ioAddr == OFF_MISC);
  end

  assign fwdStb = ioStb && !cfgOn;
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trapdoor_pkg::*;
#(
  parameter int              NUM_DEV   = 2,
  parameter logic [REG_W-1:0] SLOW_TIM  = 8'h6B,
  parameter logic [REG_W-1:0] FAST_TIM  = 8'h58,
  parameter logic [REG_W-1:0] SLOW_ADDR = 8'h30,
  parameter logic [REG_W-1:0] FAST_ADDR = 8'h20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clkFast,
  input  cfgStrobe_t               strb,
  input  logic [ADDR_W-1:0]        ioAddr,
  input  logic [REG_W-1:0]         wrByte,
  output logic [REG_W-1:0]         cfgRdByte,
  output logic [NUM_DEV*REG_W-1:0] rdTimOut,
  output logic [NUM_DEV*REG_W-1:0] wrTimOut,
  output logic [REG_W-1:0]         addrOut,
  output logic                     overrideOn
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [REG_W-1:0] rdTim [NUM_DEV];
  logic [REG_W-1:0] wrTim [NUM_DEV];
  logic [REG_W-1:0] ctrlReg, addrReg, defTim, defAddr;
  logic [DEV_W-1:0] devSel;
  logic             probeArm;

  // strap defaults follow the live speed strap
  assign defTim  = clkFast ? FAST_TIM  : SLOW_TIM;
  assign defAddr = clkFast ? FAST_ADDR : SLOW_ADDR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < NUM_DEV; d++) begin
        rdTim[d] <= defTim;
        wrTim[d] <= defTim;
      end
      ctrlReg  <= '0;
      addrReg  <= defAddr;
      devSel   <= '0;
      probeArm <= 1'b0;
    end else begin
      for (int d = 0; d < NUM_DEV; d++) begin
        if (strb.wrRdTim && (devSel == DEV_W'(d))) rdTim[d] <= wrByte;
        if (strb.wrWrTim && (devSel == DEV_W'(d))) wrTim[d] <= wrByte;
      end
      if (strb.wrCtrl)  ctrlReg  <= wrByte;
      if (strb.wrProbe) probeArm <= (wrByte == PROBE_CODE);
      if (strb.wrMisc) begin
        // small values pick a device, larger ones are the shared setup
        if (wrByte < REG_W'(NUM_DEV)) devSel  <= wrByte[DEV_W-1:0];
        else                          addrReg <= wrByte;
      end
    end
  end

  assign overrideOn = (ctrlReg == CTRL_COMMIT);

  always_comb begin
    cfgRdByte = '0;
    case (ioAddr)
      OFF_RDTIM: cfgRdByte = rdTim[devSel];
      OFF_WRTIM: cfgRdByte = wrTim[devSel];
      OFF_CTRL:  cfgRdByte = ctrlReg;
      OFF_PROBE: cfgRdByte = {{(REG_W-1){1'b0}}, probeArm & clkFast};
      OFF_MISC:  cfgRdByte = addrReg;
      default:   cfgRdByte = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign rdTimOut[g*REG_W +: REG_W] = overrideOn ? rdTim[g] : defTim;
    assign wrTimOut[g*REG_W +: REG_W] = overrideOn ? wrTim[g] : defTim;
  end

  assign addrOut = overrideOn ? addrReg : defAddr;
endmodule

// File: rtl/cfg_trapdoor.sv
module cfg_trapdoor
  import trapdoor_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          clkFast,
  input  logic          ioStb,
  input  logic          ioWr,
  input  logic          ioWide,
  input  logic [2:0]    ioAddr,
  input  logic [15:0]   ioWdata,
  output logic [15:0]   ioRdata,
  output logic          tfStb,
  output logic          tfWr,
  output logic          tfWide,
  output logic [2:0]    tfAddr,
  output logic [15:0]   tfWdata,
  input  logic [15:0]   tfRdata,
  output logic [15:0]   rdTiming,
  output logic [15:0]   wrTiming,
  output logic [7:0]    addrSetup,
  output logic          overrideOn
);
  localparam int NUM_DEV = 2;

  cfgStrobe_t       strb;
  logic             cfgMode;
  logic [REG_W-1:0] cfgRdByte;

  trap_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ioStb  (ioStb),
    .ioWr   (ioWr),
    .ioWide (ioWide),
    .ioAddr (ioAddr),
    .wrByte (ioWdata[REG_W-1:0]),
    .strb   (strb),
    .fwdStb (tfStb)
  );

  trap_regs #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .clkFast    (clkFast),
    .strb       (strb),
    .ioAddr     (ioAddr),
    .wrByte     (ioWdata[REG_W-1:0]),
    .cfgRdByte  (cfgRdByte),
    .rdTimOut   (rdTiming),
    .wrTimOut   (wrTiming),
    .addrOut    (addrSetup),
    .overrideOn (overrideOn)
  );

  assign cfgMode = strb.cfgMode;
  assign tfWr    = ioWr;
  assign tfWide  = ioWide;
  assign tfAddr  = ioAddr;
  assign tfWdata = ioWdata;
  assign ioRdata = cfgMode ? {{(DATA_W-REG_W){1'b0}}, cfgRdByte} : tfRdata;
endmodule

// File: rtl/trap_checker.sv
module trap_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgMode,
  input logic        ioStb,
  input logic        ioWr,
  input logic        ioWide,
  input logic [2:0]  ioAddr,
  input logic [15:0] ioWdata,
  input logic        tfStb,
  input logic        overrideOn
);
  p_locked_forward_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |-> (tfStb == ioStb));

  p_open_blocks_port_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode |-> !tfStb);

  p_open_after_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgMode) |-> $past(ioStb && ioWr && !ioWide && ioAddr == 3'd2 && ioWdata[7:0] == 8'h03));

  p_close_on_key_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && ioStb && ioWr && !ioWide && ioAddr == 3'd2 && ioWdata[7:0] == 8'h83) |=> !cfgMode);

  p_commit_sets_override_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && ioStb && ioWr && ioAddr == 3'd3 && ioWdata[7:0] == 8'h85) |=> overrideOn);

  p_locked_keeps_ctrl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |=> $stable(overrideOn));
endmodule

bind cfg_trapdoor trap_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgMode    (cfgMode),
  .ioStb      (ioStb),
  .ioWr       (ioWr),
  .ioWide     (ioWide),
  .ioAddr     (ioAddr),
  .ioWdata    (ioWdata),
  .tfStb      (tfStb),
  .overrideOn (overrideOn)
);

// File: tb/sim_cfg_trapdoor.sv
module sim_cfg_trapdoor;
  logic clk = 1'b0, rstN = 1'b0, clkFast = 1'b0;
  logic ioStb = 1'b0, ioWr = 1'b0, ioWide = 1'b0;
  logic [2:0] ioAddr = '0;
  logic [15:0] ioWdata = '0, ioRdata, tfWdata, tfRdata;
  logic tfStb, tfWr, tfWide, overrideOn;
  logic [2:0] tfAddr;
  logic [15:0] rdTiming, wrTiming;
  logic [7:0] addrSetup;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign tfRdata = 16'hA500 | {13'd0, tfAddr};

  cfg_trapdoor u0 (.*);

  function automatic logic [7:0] defTim(input logic f); return f ? 8'h58 : 8'h6B; endfunction
  function automatic logic [7:0] defAddr(input logic f); return f ? 8'h20 : 8'h30; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic wide, input logic [2:0] a,
                     input logic [15:0] d, output logic [15:0] rd, output logic fwd);
    @(negedge clk);
    ioStb = 1'b1; ioWr = wr; ioWide = wide; ioAddr = a; ioWdata = d;
    #2;
    rd = ioRdata; fwd = tfStb;
    @(posedge clk);
    #1 ioStb = 1'b0;
  endtask

  task automatic doReset(input logic f);
    @(negedge clk); rstN = 1'b0; clkFast = f;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic unlock();
    logic [15:0] r; logic s;
    acc(0, 1, 3'd1, 0, r, s);
    acc(0, 1, 3'd1, 0, r, s);
    acc(1, 0, 3'd2, 16'h0003, r, s);
  endtask

  logic [7:0] mRd [2], mWr [2];
  logic [7:0] mAddr;
  int mDev;

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r; logic s;
    int arm; bit open;
    void'($urandom(32'd4321));
    doReset(0);
    #2;
    // R1 reset state, slow strap
    chk("R1 rdTiming", rdTiming, 16'h6B6B);
    chk("R1 wrTiming", wrTiming, 16'h6B6B);
    chk("R1 addrSetup", addrSetup, 8'h30);
    chk("R1 overrideOn", overrideOn, 0);

    // R2 locked pass-through
    acc(0, 1, 3'd4, 0, r, s);
    chk("R2 rdata", r, 16'hA504);
    chk("R2 tfStb", s, 1);
    // R12 closed write to offset 0 must not reach the bank
    acc(1, 0, 3'd0, 16'h0011, r, s);
    chk("R12 fwd", s, 1);

    // R4 broken handshakes
    acc(0, 1, 3'd1, 0, r, s); acc(0, 0, 3'd1, 0, r, s);
    acc(0, 1, 3'd1, 0, r, s); acc(1, 0, 3'd2, 16'h0003, r, s);
    acc(0, 1, 3'd0, 0, r, s);
    chk("R4 byte read breaks", r, 16'hA500);
    acc(0, 1, 3'd1, 0, r, s); acc(0, 1, 3'd1, 0, r, s);
    acc(1, 0, 3'd2, 16'h0004, r, s); acc(1, 0, 3'd2, 16'h0003, r, s);
    acc(0, 1, 3'd0, 0, r, s);
    chk("R4 wrong key breaks", r, 16'hA500);

    // R3 three reads then key still opens
    acc(0, 1, 3'd1, 0, r, s);
    unlock();
    acc(0, 1, 3'd0, 0, r, s);
    chk("R3 open read", r, 16'h006B);
    chk("R12 closed write lost", r, 16'h006B);
    chk("R5 tfStb low", s, 0);

    // R6 other key value ignored
    acc(1, 0, 3'd2, 16'h0055, r, s);
    acc(0, 1, 3'd1, 0, r, s);
    chk("R6 still open", r, 16'h006B);

    // R7/R10 random programming, override off
    mRd[0] = 8'h6B; mRd[1] = 8'h6B; mWr[0] = 8'h6B; mWr[1] = 8'h6B; mDev = 0;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      mDev = $urandom % 2; a = 8'($urandom); b = 8'($urandom);
      acc(1, 0, 3'd6, 16'(mDev), r, s);
      acc(1, 0, 3'd0, {8'hEE, a}, r, s);
      acc(1, 0, 3'd1, {8'hEE, b}, r, s);
      mRd[mDev] = a; mWr[mDev] = b;
      acc(0, 1, 3'd0, 0, r, s);
      chk("R7 read timing", r, {8'd0, a});
      acc(0, 1, 3'd1, 0, r, s);
      chk("R7 write timing", r, {8'd0, b});
    end
    chk("R10 defaults shown", rdTiming, 16'h6B6B);

    // R8 address setup, device kept
    mAddr = 8'h10;
    acc(1, 0, 3'd6, 16'h0010, r, s);
    acc(0, 1, 3'd6, 0, r, s);
    chk("R8 addr readback", r, 16'h0010);
    acc(0, 1, 3'd0, 0, r, s);
    chk("R8 device kept", r, {8'd0, mRd[mDev]});

    // R9 commit
    acc(1, 0, 3'd3, 16'h0085, r, s);
    #2 chk("R9 override on", overrideOn, 1);
    chk("R10 rdTiming", rdTiming, {mRd[1], mRd[0]});
    chk("R10 wrTiming", wrTiming, {mWr[1], mWr[0]});
    chk("R10 addrSetup", addrSetup, mAddr);
    acc(0, 1, 3'd3, 0, r, s);
    chk("R9 ctrl readback", r, 16'h0085);
    acc(1, 0, 3'd3, 16'h0084, r, s);
    #2 chk("R9 override off", overrideOn, 0);
    acc(1, 0, 3'd3, 16'h0085, r, s);

    // R6 close
    acc(1, 0, 3'd2, 16'h0083, r, s);
    acc(0, 1, 3'd0, 0, r, s);
    chk("R6 closed rdata", r, 16'hA500);
    chk("R6 closed fwd", s, 1);
    acc(1, 0, 3'd3, 16'h0000, r, s);
    #2 chk("R12 override kept", overrideOn, 1);

    // R1 fast strap, R11 probe
    doReset(1);
    #2;
    chk("R1 fast rdTiming", rdTiming, 16'h5858);
    chk("R1 fast addr", addrSetup, 8'h20);
    chk("R1 fast override", overrideOn, 0);
    unlock();
    acc(0, 1, 3'd5, 0, r, s);
    chk("R11 unprobed", r, 16'h0000);
    acc(1, 0, 3'd5, 16'h00FF, r, s);
    acc(0, 1, 3'd5, 0, r, s);
    chk("R11 probed", r, 16'h0001);
    acc(1, 0, 3'd5, 16'h0000, r, s);
    acc(0, 1, 3'd5, 0, r, s);
    chk("R11 cleared", r, 16'h0000);
    acc(1, 0, 3'd2, 16'h0083, r, s);

    // R2/R3/R4/R5/R6 random traffic against a handshake model
    arm = 0; open = 0;
    for (int i = 0; i < 300; i++) begin
      logic wr, wide; logic [2:0] a; logic [7:0] d; int k;
      wr = 1'($urandom); wide = 1'($urandom);
      k = $urandom % 4;
      a = (k < 2) ? 3'd1 : (k == 2) ? 3'd2 : 3'($urandom);
      k = $urandom % 3;
      d = (k == 0) ? 8'h03 : (k == 1) ? 8'h83 : 8'($urandom);
      if (a == 3'd3 || a == 3'd5) wr = 1'b0;
      acc(wr, wide, a, {8'h00, d}, r, s);
      chk("R5 R2 forward by model", s, !open);
      if (!open) chk("R2 rdata random", r, 16'hA500 | {13'd0, a});
      if (open) begin
        if (wr && !wide && a == 3'd2 && d == 8'h83) open = 0;
      end else if (!wr && wide && a == 3'd1) begin
        arm = (arm == 2) ? 2 : arm + 1;
      end else if (arm == 2 && wr && !wide && a == 3'd2 && d == 8'h03) begin
        open = 1; arm = 0;
      end else arm = 0;
    end
    chk("R4 R3 model check ran", 1, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule